// File: doc/BRIEF.md
# Fault Record Capture

This block freezes a diagnostic snapshot when the processor takes a program interrupt. A one-cycle strobe delivers the 16-bit interrupt code, the byte length of the offending instruction, the status-word address and the interrupt-mask nibble. The block latches these values and derives the address of the faulting instruction. Translation faults leave the status-word address pointing at that instruction. Protection faults leave it pointing just past the instruction.

The block then reads a window of bytes through a byte-wide read port, one byte per cycle. The window is centred on the status-word address, so it always contains the faulting instruction. It also labels the record. Every code in the storage-fault family belongs to one category. Each record is marked either resolvable or terminal, based on the mask state and on a disabled-reference hint.

The captured fields stay readable and unchanged until the next accepted strobe or a synchronous clear.

Top module: `fault_record_capture`

## Requirements
- R1: After reset, and in the cycle after `clr_i` is sampled high, all record outputs are zero. `busy_o`, `done_o`, `overrun_o` and `mem_rd_o` are also low. A clear takes priority over a strobe in the same cycle.
- R2: For translation codes 0x0010, 0x0011, 0x0038, 0x0039, 0x003A and 0x003B, `rec_fail_addr_o` equals the captured status-word address.
- R3: For the protection code 0x0004, `rec_fail_addr_o` equals the status-word address minus the instruction length, modulo 2^AW.
- R4: `rec_text_o` holds 2*WIN_HALF bytes. Byte k (k = 0 first) is read from address paddr − WIN_HALF + k. Byte 0 occupies the most significant byte of `rec_text_o`.
- R5: `rec_code_o` holds the captured interrupt code. `rec_cat_o` is 1 for the seven codes of R2 and R3, and 0 for any other code.
- R6: `rec_terminal_o` is 0 only for a translation code taken while the mask nibble equals 4'h7, or while `dref_i` is 1. The protection code and any other code are always terminal.
- R7: An accepted strobe raises `busy_o` at the next clock edge. `busy_o` stays high for exactly 2*WIN_HALF cycles. `done_o` then pulses for one cycle, in the first cycle with `busy_o` low.
- R8: A strobe that arrives while `busy_o` is high changes no record field. It also sets `overrun_o`, which stays set until `clr_i`.
- R9: While idle with no strobe and no clear, every record output holds its value.
- R10: `rec_len_o` holds the captured instruction length in bytes. Legal values are 2, 4 and 6.
- R11: `mem_rd_o` is high in each busy cycle and low otherwise. `mem_addr_o` starts at paddr − WIN_HALF and advances by one each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of the record |
| irq_i | input | 1 | Program interrupt strobe |
| icode_i | input | 16 | Interrupt code |
| ilen_i | input | 3 | Instruction length in bytes |
| paddr_i | input | AW | Status-word instruction address |
| mask_i | input | 4 | Interrupt-mask nibble (7 = enabled) |
| dref_i | input | 1 | Access targets a disabled-reference region |
| mem_rd_o | output | 1 | Byte read request |
| mem_addr_o | output | AW | Byte read address |
| mem_data_i | input | 8 | Byte read data, same cycle |
| busy_o | output | 1 | Window fetch in progress |
| done_o | output | 1 | One-cycle completion pulse |
| overrun_o | output | 1 | Sticky: strobe arrived while busy |
| rec_code_o | output | 16 | Captured interrupt code |
| rec_len_o | output | 3 | Captured instruction length |
| rec_fail_addr_o | output | AW | Derived faulting instruction address |
| rec_text_o | output | 16*WIN_HALF | Instruction text window |
| rec_cat_o | output | 1 | Code belongs to the storage-fault category |
| rec_terminal_o | output | 1 | Fault cannot be resolved |

## Verification
The bench builds the block with AW = 32, WIN_HALF = 6 and MAX_ILEN = 6. These are the sizes at which a six-byte instruction lands fully in either half of the window. With a 32-bit address, a status-word address of 0x3 makes the window start wrap below zero. A protection fault near zero also exercises the modular subtraction of the length. The byte-by-byte address walk is observed on the read port for every scenario.

// File: rtl/fault_record_pkg.sv
package fault_record_pkg;

   localparam logic [15:0] CODE_PROTECT = 16'h0004;
   localparam logic [15:0] CODE_SEG     = 16'h0010;
   localparam logic [15:0] CODE_PAGE    = 16'h0011;
   localparam logic [15:0] CODE_ASPACE  = 16'h0038;
   localparam logic [15:0] CODE_REG1    = 16'h0039;
   localparam logic [15:0] CODE_REG2    = 16'h003A;
   localparam logic [15:0] CODE_REG3    = 16'h003B;

   typedef enum logic [1:0] {
      FK_OTHER   = 2'd0,
      FK_PROTECT = 2'd1,
      FK_XLATE   = 2'd2
   } fault_kind_e;

   function automatic fault_kind_e kind_of(input logic [15:0] code);
      fault_kind_e k;
      case (code)
         CODE_PROTECT: k = FK_PROTECT;
         CODE_SEG, CODE_PAGE, CODE_ASPACE,
         CODE_REG1, CODE_REG2, CODE_REG3: k = FK_XLATE;
         default: k = FK_OTHER;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/frc_classifier.sv
module frc_classifier
   import fault_record_pkg::*;
#(
   parameter int AW           = 32,
   parameter int LW           = 3,
   parameter logic [3:0] MASK_ON = 4'h7,
   parameter bit BACKSTEP_PROT   = 1'b1
) (
   input  logic [15:0]   code_i,
   input  logic [LW-1:0] len_i,
   input  logic [AW-1:0] addr_i,
   input  logic [3:0]    mask_i,
   input  logic          dref_i,
   output logic          cat_o,
   output logic          terminal_o,
   output logic [AW-1:0] fail_addr_o
);
   fault_kind_e kind;
   logic        enabled;

   always_comb begin
      kind       = kind_of(code_i);
      enabled    = (mask_i == MASK_ON);
      cat_o      = (kind != FK_OTHER);
      terminal_o = !((kind == FK_XLATE) && (enabled || dref_i));
   end

   generate
      if (BACKSTEP_PROT) begin : g_backstep
         always_comb begin
            if (kind == FK_PROTECT) fail_addr_o = addr_i - AW'(len_i);
            else                    fail_addr_o = addr_i;
         end
      end else begin : g_direct
         always_comb fail_addr_o = addr_i;
      end
   endgenerate

endmodule

// File: rtl/frc_window_fetch.sv
module frc_window_fetch #(
   parameter int AW       = 32,
   parameter int WIN_HALF = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr_i,
   input  logic                   start_i,
   input  logic [AW-1:0]          addr_i,
   output logic                   rd_o,
   output logic [AW-1:0]          rd_addr_o,
   input  logic [7:0]             rd_data_i,
   output logic                   busy_o,
   output logic                   done_o,
   output logic [16*WIN_HALF-1:0] text_o
);
   localparam int NBYTES = 2 * WIN_HALF;
   localparam int IW     = (NBYTES > 1) ? $clog2(NBYTES) : 1;
   localparam logic [IW-1:0] LAST = IW'(NBYTES - 1);

   logic [IW-1:0] idx;
   logic [AW-1:0] base;
   logic          busy;
   logic          done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         idx  <= '0;
         base <= '0;
      end else if (clr_i) begin
         busy <= 1'b0;
         done <= 1'b0;
         idx  <= '0;
         base <= '0;
      end else begin
         done <= 1'b0;
         if (start_i && !busy) begin
            busy <= 1'b1;
            idx  <= '0;
            base <= addr_i - AW'(WIN_HALF);
         end else if (busy) begin
            if (idx == LAST) begin
               busy <= 1'b0;
               done <= 1'b1;
               idx  <= '0;
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end

   genvar g;
   generate
      for (g = 0; g < NBYTES; g++) begin : g_byte
         logic [7:0] slot;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               slot <= '0;
            else if (clr_i)                           slot <= '0;
            else if (busy && (idx == IW'(g)))         slot <= rd_data_i;
         end
         assign text_o[8*(NBYTES-g)-1 -: 8] = slot;
      end
   endgenerate

   assign rd_o      = busy;
   assign rd_addr_o = base + AW'(idx);
   assign busy_o    = busy;
   assign done_o    = done;

endmodule

// File: rtl/fault_record_capture.sv
module fault_record_capture #(
   parameter int AW       = 32,
   parameter int WIN_HALF = 6,
   parameter int MAX_ILEN = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr_i,
   input  logic                   irq_i,
   input  logic [15:0]            icode_i,
   input  logic [2:0]             ilen_i,
   input  logic [AW-1:0]          paddr_i,
   input  logic [3:0]             mask_i,
   input  logic                   dref_i,
   output logic                   mem_rd_o,
   output logic [AW-1:0]          mem_addr_o,
   input  logic [7:0]             mem_data_i,
   output logic                   busy_o,
   output logic                   done_o,
   output logic                   overrun_o,
   output logic [15:0]            rec_code_o,
   output logic [2:0]             rec_len_o,
   output logic [AW-1:0]          rec_fail_addr_o,
   output logic [16*WIN_HALF-1:0] rec_text_o,
   output logic                   rec_cat_o,
   output logic                   rec_terminal_o
);
   localparam int LW = 3;

   generate
      if (WIN_HALF < MAX_ILEN) begin : g_bad_window
         initial $error("window half smaller than longest instruction");
      end
      if (AW < 8) begin : g_bad_aw
         initial $error("address width too small");
      end
      if (MAX_ILEN > 7) begin : g_bad_len
         initial $error("length field cannot hold MAX_ILEN");
      end
   endgenerate

   logic          accept;
   logic          busy;
   logic          cls_cat;
   logic          cls_term;
   logic [AW-1:0] cls_fail;

   assign accept = irq_i && !busy && !clr_i;

   frc_classifier #(.AW(AW), .LW(LW)) u_cls (
      .code_i      (icode_i),
      .len_i       (ilen_i),
      .addr_i      (paddr_i),
      .mask_i      (mask_i),
      .dref_i      (dref_i),
      .cat_o       (cls_cat),
      .terminal_o  (cls_term),
      .fail_addr_o (cls_fail)
   );

   frc_window_fetch #(.AW(AW), .WIN_HALF(WIN_HALF)) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr_i),
      .start_i   (accept),
      .addr_i    (paddr_i),
      .rd_o      (mem_rd_o),
      .rd_addr_o (mem_addr_o),
      .rd_data_i (mem_data_i),
      .busy_o    (busy),
      .done_o    (done_o),
      .text_o    (rec_text_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_code_o      <= '0;
         rec_len_o       <= '0;
         rec_fail_addr_o <= '0;
         rec_cat_o       <= 1'b0;
         rec_terminal_o  <= 1'b0;
         overrun_o       <= 1'b0;
      end else if (clr_i) begin
         rec_code_o      <= '0;
         rec_len_o       <= '0;
         rec_fail_addr_o <= '0;
         rec_cat_o       <= 1'b0;
         rec_terminal_o  <= 1'b0;
         overrun_o       <= 1'b0;
      end else begin
         if (accept) begin
            rec_code_o      <= icode_i;
            rec_len_o       <= ilen_i;
            rec_fail_addr_o <= cls_fail;
            rec_cat_o       <= cls_cat;
            rec_terminal_o  <= cls_term;
         end
         if (irq_i && busy) overrun_o <= 1'b1;
      end
   end

   assign busy_o = busy;

endmodule

// File: rtl/frc_checker.sv
module frc_checker #(
   parameter int AW       = 32,
   parameter int WIN_HALF = 6
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   clr_i,
   input logic                   irq_i,
   input logic                   mem_rd_o,
   input logic [AW-1:0]          mem_addr_o,
   input logic                   busy_o,
   input logic                   done_o,
   input logic                   overrun_o,
   input logic [15:0]            rec_code_o,
   input logic [2:0]             rec_len_o,
   input logic [AW-1:0]          rec_fail_addr_o,
   input logic [16*WIN_HALF-1:0] rec_text_o,
   input logic                   rec_cat_o,
   input logic                   rec_terminal_o
);
   localparam int NBYTES = 2 * WIN_HALF;
   localparam int CW     = $clog2(NBYTES + 1) + 1;

   logic [CW-1:0] busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       busy_cnt <= '0;
      else if (!busy_o) busy_cnt <= '0;
      else              busy_cnt <= busy_cnt + 1'b1;
   end

   AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o && busy_cnt == CW'(NBYTES)); // R7

   AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      irq_i && busy_o && !clr_i |=> overrun_o); // R8

   AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_o && !clr_i |=> overrun_o); // R8

   AST_BUSY_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !clr_i |=> $stable(rec_code_o) && $stable(rec_len_o)
                           && $stable(rec_fail_addr_o) && $stable(rec_terminal_o)); // R8

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && !irq_i && !clr_i |=> $stable(rec_code_o) && $stable(rec_text_o)
                                      && $stable(rec_fail_addr_o) && $stable(rec_cat_o)); // R9

   AST_ADDR_WALK: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_o && $past(mem_rd_o) |-> mem_addr_o == $past(mem_addr_o) + AW'(1)); // R11

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !busy_o && !overrun_o && rec_code_o == '0 && rec_text_o == '0); // R1

   AST_OUTSIDE_TERMINAL: assert property (@(posedge clk) disable iff (!rst_n)
      !rec_cat_o && !busy_o && rec_code_o != '0 |-> rec_terminal_o); // R6

endmodule

bind fault_record_capture frc_checker #(.AW(AW), .WIN_HALF(WIN_HALF)) u_frc_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .clr_i           (clr_i),
   .irq_i           (irq_i),
   .mem_rd_o        (mem_rd_o),
   .mem_addr_o      (mem_addr_o),
   .busy_o          (busy_o),
   .done_o          (done_o),
   .overrun_o       (overrun_o),
   .rec_code_o      (rec_code_o),
   .rec_len_o       (rec_len_o),
   .rec_fail_addr_o (rec_fail_addr_o),
   .rec_text_o      (rec_text_o),
   .rec_cat_o       (rec_cat_o),
   .rec_terminal_o  (rec_terminal_o)
);

// File: tb/fault_record_capture_tb_top.sv
`timescale 1ns/1ps
module fault_record_capture_tb_top;
   localparam int AW = 32;
   localparam int WH = 6;
   localparam int NB = 2 * WH;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            clr_i = 1'b0;
   logic            irq_i = 1'b0;
   logic [15:0]     icode_i = '0;
   logic [2:0]      ilen_i = '0;
   logic [AW-1:0]   paddr_i = '0;
   logic [3:0]      mask_i = '0;
   logic            dref_i = 1'b0;
   logic            mem_rd_o;
   logic [AW-1:0]   mem_addr_o;
   logic [7:0]      mem_data_i;
   logic            busy_o, done_o, overrun_o;
   logic [15:0]     rec_code_o;
   logic [2:0]      rec_len_o;
   logic [AW-1:0]   rec_fail_addr_o;
   logic [8*NB-1:0] rec_text_o;
   logic            rec_cat_o, rec_terminal_o;

   logic [7:0] mem [0:255];
   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   assign mem_data_i = mem[mem_addr_o[7:0]];

   fault_record_capture #(.AW(AW), .WIN_HALF(WH), .MAX_ILEN(6)) dut_i (.*);

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit is_xlate(input logic [15:0] c);
      return c == 16'h10 || c == 16'h11 || c == 16'h38 || c == 16'h39 || c == 16'h3A || c == 16'h3B;
   endfunction

   task automatic check_zero(input string req);
      chk(rec_code_o == '0 && rec_len_o == '0 && rec_fail_addr_o == '0 && rec_text_o == '0
          && !rec_cat_o && !rec_terminal_o, req, {rec_code_o, rec_fail_addr_o}, 0);
      chk(!busy_o && !done_o && !overrun_o && !mem_rd_o, req,
          {busy_o, done_o, overrun_o, mem_rd_o}, 0);
   endtask

   // One accepted fault; optional strobe injected while busy.
   task automatic run_fault(input logic [15:0] code, input logic [2:0] len, input logic [AW-1:0] addr,
                            input logic [3:0] mask, input bit dref, input bit inject, input bit exp_ov);
      logic [AW-1:0] exp_fail;
      logic [8*NB-1:0] exp_text;
      bit exp_cat, exp_term, walk_ok;
      int busy_n;
      exp_fail = (code == 16'h4) ? addr - AW'(len) : addr;
      exp_cat  = is_xlate(code) || code == 16'h4;
      exp_term = !(is_xlate(code) && (mask == 4'h7 || dref));
      for (int k = 0; k < NB; k++) exp_text[8*(NB-k)-1 -: 8] = mem[8'(addr - AW'(WH) + AW'(k))];
      irq_i = 1'b1; icode_i = code; ilen_i = len; paddr_i = addr; mask_i = mask; dref_i = dref;
      @(negedge clk);
      busy_n = 0; walk_ok = 1'b1;
      for (int k = 1; k <= NB; k++) begin
         if (busy_o) busy_n++;
         if (!mem_rd_o || mem_addr_o != addr - AW'(WH) + AW'(k - 1)) walk_ok = 1'b0;
         irq_i = inject && (k == 3);
         icode_i = inject ? 16'hBEEF : code;
         paddr_i = inject ? addr + 32'h40 : addr;
         @(negedge clk);
      end
      irq_i = 1'b0;
      chk(busy_n == NB && !busy_o && done_o, "R7 busy span and done", {busy_n, busy_o, done_o}, {NB, 2'b01});
      chk(walk_ok && !mem_rd_o, "R11 read port walk", walk_ok, 1);
      chk(rec_code_o == code && rec_cat_o == exp_cat, "R5 code and category", {rec_code_o, rec_cat_o}, {code, exp_cat});
      chk(rec_len_o == len, "R10 length", rec_len_o, len);
      chk(rec_fail_addr_o == exp_fail, (code == 16'h4) ? "R3 backed-up address" : "R2 faulting address",
          rec_fail_addr_o, exp_fail);
      chk(rec_terminal_o == exp_term, "R6 terminal flag", rec_terminal_o, exp_term);
      chk(rec_text_o == exp_text, "R4 text window", rec_text_o, exp_text);
      chk(overrun_o == exp_ov, "R8 overrun flag", overrun_o, exp_ov);
      @(negedge clk);
      chk(!done_o, "R7 done single pulse", done_o, 0);
   endtask

   task automatic t_hold;
      logic [15:0] c; logic [AW-1:0] f; logic [8*NB-1:0] t;
      c = rec_code_o; f = rec_fail_addr_o; t = rec_text_o;
      repeat (5) @(negedge clk);
      chk(rec_code_o == c && rec_fail_addr_o == f && rec_text_o == t, "R9 idle hold", rec_code_o, c);
   endtask

   task automatic t_clear;
      clr_i = 1'b1; irq_i = 1'b1; icode_i = 16'h11;
      @(negedge clk);
      clr_i = 1'b0; irq_i = 1'b0;
      check_zero("R1 clear wins over strobe");
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
      repeat (3) @(negedge clk);
      check_zero("R1 reset state");
      rst_n = 1'b1;
      @(negedge clk);
      run_fault(16'h11, 3'd6, 32'h0000_0156, 4'h7, 1'b0, 1'b0, 1'b0); // R2 enabled, resolvable
      t_hold();
      run_fault(16'h10, 3'd4, 32'h0000_20A0, 4'h4, 1'b0, 1'b0, 1'b0); // R6 disabled -> terminal
      run_fault(16'h3A, 3'd2, 32'h0000_0080, 4'h4, 1'b1, 1'b0, 1'b0); // R6 disabled-reference
      run_fault(16'h04, 3'd4, 32'h0000_0002, 4'h7, 1'b0, 1'b0, 1'b0); // R3 wrap below zero
      run_fault(16'h07, 3'd2, 32'h0000_0003, 4'h7, 1'b0, 1'b0, 1'b0); // R5 outside category
      run_fault(16'h3B, 3'd6, 32'h0000_0C40, 4'h7, 1'b0, 1'b1, 1'b1); // R8 strobe while busy
      run_fault(16'h39, 3'd4, 32'h0000_0010, 4'h7, 1'b0, 1'b0, 1'b1); // R8 sticky
      t_clear();
      run_fault(16'h38, 3'd6, 32'h0000_00F8, 4'h7, 1'b0, 1'b0, 1'b0); // R2 after clear
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule